// File: doc/BRIEF.md
# Data Memory Address Generator

This unit sits beside the load/store path of a small processor core. For each memory instruction it forms the effective data-memory address. For the modes that move a pointer, it also produces the updated 16-bit pointer and a write-enable back to the register pair that holds it. The core presents the request for one cycle with `op_valid`. The unit registers its answer, so the result is visible on the outputs in the following cycle.

Five addressing modes exist. Direct mode takes the 16-bit address carried by the instruction. Indirect mode uses one of three pointers unchanged. Displacement mode adds an unsigned 6-bit offset to a base in the second or third pointer. Pre-decrement mode lowers the pointer before use. Post-increment mode raises it after use.

All pointer arithmetic wraps modulo 2^16. A request that combines a mode with a pointer it may not use, or that carries an unassigned code, is reported as illegal. An illegal request writes nothing and produces no address.

The output stage is a three-state machine: `ST_IDLE` (no request in the last cycle), `ST_ADDR` (a legal request was taken; the address is valid) and `ST_FAULT` (an illegal request was taken). The transitions are the same from every state:
- to `ST_ADDR` on a legal request;
- to `ST_FAULT` on an illegal request;
- to `ST_IDLE` when `op_valid` is low.

Reset enters `ST_IDLE`.

Top module: `dmag_addr_gen`

## Requirements
- R1: After reset, and until the first request, `ea_valid`, `ptr_we` and `illegal` are 0, and `ea` and `ptr_new` are 0.
- R2: A request sampled at a rising edge with `op_valid`=1 is reflected on the outputs after that edge. A cycle with `op_valid`=0 gives `ea_valid`=0, `ptr_we`=0 and `illegal`=0 after the next edge.
- R3: Mode code 3'b000 (direct) gives `ea` = `direct_addr`, for any 16-bit value. It gives `ptr_we`=0 and ignores `ptr_sel`, including code 2'b11.
- R4: Mode code 3'b001 (indirect) with `ptr_sel` 2'b00 (X), 2'b01 (Y) or 2'b10 (Z) gives `ea` = `ptr_val`, `ptr_new` = `ptr_val` and `ptr_we`=0.
- R5: Mode code 3'b010 (displacement) with `ptr_sel` Y or Z gives `ea` = `ptr_val` + zero-extended `disp` (0 to 63), `ptr_new` = `ptr_val` and `ptr_we`=0.
- R6: Mode code 3'b010 with `ptr_sel` X gives `illegal`=1, `ea_valid`=0 and `ptr_we`=0.
- R7: Mode code 3'b011 (pre-decrement) gives `ea` = `ptr_new` = `ptr_val` − 1 and `ptr_we`=1.
- R8: Mode code 3'b100 (post-increment) gives `ea` = `ptr_val`, `ptr_new` = `ptr_val` + 1 and `ptr_we`=1.
- R9: Pointer arithmetic wraps modulo 2^16:
  - pre-decrement of 0x0000 yields 0xFFFF;
  - post-increment of 0xFFFF writes 0x0000;
  - displacement 63 on 0xFFF0 yields 0x002F.
- R10: When `ptr_we`=1, `ptr_wr_sel` equals the `ptr_sel` of the request that caused the write.
- R11: Mode codes 3'b101 to 3'b111 give `illegal`=1 with `ptr_we`=0. So does `ptr_sel` 2'b11 in any pointer mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | A memory instruction is presented this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z, 3 reserved |
| direct_addr | input | 16 | Address field for direct mode |
| ptr_val | input | 16 | Current value of the selected pointer |
| disp | input | 6 | Unsigned displacement |
| ea | output | 16 | Effective data address |
| ea_valid | output | 1 | `ea` belongs to a legal request taken last cycle |
| ptr_new | output | 16 | Value to write back to the pointer |
| ptr_we | output | 1 | Write `ptr_new` into the pointer |
| ptr_wr_sel | output | 2 | Pointer that `ptr_we` targets |
| illegal | output | 1 | The last request was illegal |

## Verification
The clocked properties assume two things:
- while `op_valid` is high, `mode` and `ptr_sel` are settled before the sampling edge;
- `ptr_val` is the value of the pointer named by `ptr_sel`.

The bench meets both by changing inputs only on the falling clock edge. It holds each request for exactly one rising edge and then drops `op_valid`, so every answer is seen in isolation. The pointer values it feeds are chosen freely, including the wrap points 0x0000, 0xFFFF and 0xFFF0, because the unit itself keeps no copy of the pointers.

// File: rtl/dmag_pkg.sv
package dmag_pkg;

    typedef enum logic [2:0] {
        MD_DIRECT  = 3'b000,
        MD_IND     = 3'b001,
        MD_DISP    = 3'b010,
        MD_PREDEC  = 3'b011,
        MD_POSTINC = 3'b100
    } mode_e;

    typedef enum logic [1:0] {
        PS_X   = 2'b00,
        PS_Y   = 2'b01,
        PS_Z   = 2'b10,
        PS_RSV = 2'b11
    } psel_e;

    typedef enum logic [1:0] {
        ADD_ZERO,
        ADD_DISP,
        ADD_DEC,
        ADD_INC
    } addend_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_FAULT
    } ostate_e;

    typedef struct packed {
        logic    legal;
        logic    use_direct;
        logic    ea_from_sum;
        logic    wb;
        addend_e addend;
    } ctrl_t;

endpackage

// File: rtl/dmag_decode.sv
module dmag_decode
    import dmag_pkg::*;
(
    input  logic [2:0] mode,
    input  logic [1:0] ptr_sel,
    output ctrl_t      ctrl
);

    logic sel_ok;
    logic sel_yz;

    assign sel_ok = (ptr_sel != PS_RSV);
    assign sel_yz = (ptr_sel == PS_Y) || (ptr_sel == PS_Z);

    always_comb begin
        ctrl = '{legal: 1'b0, use_direct: 1'b0, ea_from_sum: 1'b0,
                 wb: 1'b0, addend: ADD_ZERO};
        unique case (mode)
            MD_DIRECT: begin
                ctrl.legal      = 1'b1;
                ctrl.use_direct = 1'b1;
            end
            MD_IND: begin
                ctrl.legal = sel_ok;
            end
            MD_DISP: begin
                ctrl.legal       = sel_yz;
                ctrl.ea_from_sum = 1'b1;
                ctrl.addend      = ADD_DISP;
            end
            MD_PREDEC: begin
                ctrl.legal       = sel_ok;
                ctrl.ea_from_sum = 1'b1;
                ctrl.wb          = sel_ok;
                ctrl.addend      = ADD_DEC;
            end
            MD_POSTINC: begin
                ctrl.legal  = sel_ok;
                ctrl.wb     = sel_ok;
                ctrl.addend = ADD_INC;
            end
            default: begin
                ctrl.legal = 1'b0;
            end
        endcase
    end

    // An illegal request must never ask for a pointer write (R6, R11)
    always_comb begin
        if (!ctrl.legal) begin
            assert_illegal_no_wb_R11: assert (!ctrl.wb);
        end
    end

endmodule

// File: rtl/dmag_arith.sv
module dmag_arith
    import dmag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  ctrl_t              ctrl,
    input  logic [ADDR_W-1:0]  direct_addr,
    input  logic [ADDR_W-1:0]  ptr_val,
    input  logic [DISP_W-1:0]  disp,
    output logic [ADDR_W-1:0]  ea_nxt,
    output logic [ADDR_W-1:0]  ptr_nxt
);

    localparam int PAD_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] operand;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] disp_ext;

    assign disp_ext = {{PAD_W{1'b0}}, disp};

    always_comb begin
        unique case (ctrl.addend)
            ADD_ZERO: operand = '0;
            ADD_DISP: operand = disp_ext;
            ADD_DEC:  operand = '1;
            ADD_INC:  operand = {{(ADDR_W-1){1'b0}}, 1'b1};
            default:  operand = '0;
        endcase
    end

    // One shared adder; the carry out is dropped, so results wrap (R9)
    assign sum = ptr_val + operand;

    always_comb begin
        if (ctrl.use_direct) begin
            ea_nxt = direct_addr;
        end else if (ctrl.ea_from_sum) begin
            ea_nxt = sum;
        end else begin
            ea_nxt = ptr_val;
        end
        ptr_nxt = ctrl.wb ? sum : ptr_val;
    end

    // An update must always move the pointer by exactly one (R7, R8)
    always_comb begin
        if (ctrl.wb) begin
            assert_wb_moves_ptr_R9: assert (ptr_nxt != ptr_val);
        end
    end

endmodule

// File: rtl/dmag_outreg.sv
module dmag_outreg
    import dmag_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  ctrl_t             ctrl,
    input  logic [1:0]        ptr_sel,
    input  logic [ADDR_W-1:0] ea_nxt,
    input  logic [ADDR_W-1:0] ptr_nxt,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ptr_new,
    output logic              ptr_we,
    output logic [1:0]        ptr_wr_sel,
    output logic              illegal
);

    ostate_e           state_q, state_d;
    logic [ADDR_W-1:0] ea_q, new_q;
    logic              wb_q;
    logic [1:0]        sel_q;
    logic              take;

    assign take = op_valid && ctrl.legal;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_ADDR, ST_FAULT: begin
                if (!op_valid)       state_d = ST_IDLE;
                else if (ctrl.legal) state_d = ST_ADDR;
                else                 state_d = ST_FAULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ea_q    <= '0;
            new_q   <= '0;
            wb_q    <= 1'b0;
            sel_q   <= 2'b00;
        end else begin
            state_q <= state_d;
            if (take) begin
                ea_q  <= ea_nxt;
                new_q <= ptr_nxt;
                wb_q  <= ctrl.wb;
                sel_q <= ptr_sel;
            end
        end
    end

    always_comb begin
        ea         = ea_q;
        ptr_new    = new_q;
        ptr_wr_sel = sel_q;
        ea_valid   = 1'b0;
        ptr_we     = 1'b0;
        illegal    = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ADDR: begin
                ea_valid = 1'b1;
                ptr_we   = wb_q;
            end
            ST_FAULT: illegal = 1'b1;
            default:  ;
        endcase
    end

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!ea_valid && !ptr_we && !illegal));

    assert_fault_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !ctrl.legal) |=> (illegal && !ptr_we && !ea_valid));

    assert_update_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_we |-> ((ptr_new == ea) || (ptr_new == ea + 1'b1)));

    assert_write_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ctrl.legal && ctrl.wb) |=> (ptr_we && ptr_wr_sel == $past(ptr_sel)));

endmodule

// File: rtl/dmag_addr_gen.sv
module dmag_addr_gen
    import dmag_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DISP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        mode,
    input  logic [1:0]        ptr_sel,
    input  logic [ADDR_W-1:0] direct_addr,
    input  logic [ADDR_W-1:0] ptr_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] ea,
    output logic              ea_valid,
    output logic [ADDR_W-1:0] ptr_new,
    output logic              ptr_we,
    output logic [1:0]        ptr_wr_sel,
    output logic              illegal
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] ea_nxt;
    logic [ADDR_W-1:0] ptr_nxt;

    dmag_decode u_decode (
        .mode    (mode),
        .ptr_sel (ptr_sel),
        .ctrl    (ctrl)
    );

    dmag_arith #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_arith (
        .ctrl        (ctrl),
        .direct_addr (direct_addr),
        .ptr_val     (ptr_val),
        .disp        (disp),
        .ea_nxt      (ea_nxt),
        .ptr_nxt     (ptr_nxt)
    );

    dmag_outreg #(.ADDR_W(ADDR_W)) u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .ctrl       (ctrl),
        .ptr_sel    (ptr_sel),
        .ea_nxt     (ea_nxt),
        .ptr_nxt    (ptr_nxt),
        .ea         (ea),
        .ea_valid   (ea_valid),
        .ptr_new    (ptr_new),
        .ptr_we     (ptr_we),
        .ptr_wr_sel (ptr_wr_sel),
        .illegal    (illegal)
    );

endmodule

// File: tb/dmag_addr_gen_bench.sv
`timescale 1ns/1ps
module dmag_addr_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  mode = 3'b000;
    logic [1:0]  ptr_sel = 2'b00;
    logic [15:0] direct_addr = 16'h0;
    logic [15:0] ptr_val = 16'h0;
    logic [5:0]  disp = 6'd0;
    logic [15:0] ea, ptr_new;
    logic        ea_valid, ptr_we, illegal;
    logic [1:0]  ptr_wr_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dmag_addr_gen u_dmag_addr_gen (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .mode(mode),
        .ptr_sel(ptr_sel), .direct_addr(direct_addr), .ptr_val(ptr_val),
        .disp(disp), .ea(ea), .ea_valid(ea_valid), .ptr_new(ptr_new),
        .ptr_we(ptr_we), .ptr_wr_sel(ptr_wr_sel), .illegal(illegal)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge, let one rising edge take it,
    // then sample at the next falling edge with op_valid dropped.
    task automatic issue(input logic [2:0] m, input logic [1:0] s,
                         input logic [15:0] d, input logic [15:0] p, input logic [5:0] o);
        @(negedge clk);
        op_valid = 1'b1; mode = m; ptr_sel = s; direct_addr = d; ptr_val = p; disp = o;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_ok(input string req, input logic [15:0] e_ea,
                             input logic [15:0] e_new, input logic e_we);
        chk({req, " ea_valid"}, {15'd0, ea_valid}, 16'd1);
        chk({req, " illegal"},  {15'd0, illegal},  16'd0);
        chk({req, " ea"},       ea,                e_ea);
        chk({req, " ptr_new"},  ptr_new,           e_new);
        chk({req, " ptr_we"},   {15'd0, ptr_we},   {15'd0, e_we});
    endtask

    task automatic expect_bad(input string req);
        chk({req, " illegal"},  {15'd0, illegal},  16'd1);
        chk({req, " ea_valid"}, {15'd0, ea_valid}, 16'd0);
        chk({req, " ptr_we"},   {15'd0, ptr_we},   16'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ea_valid", {15'd0, ea_valid}, 16'd0);
        chk("R1 ptr_we",   {15'd0, ptr_we},   16'd0);
        chk("R1 illegal",  {15'd0, illegal},  16'd0);
        chk("R1 ea",       ea,                16'h0000);
        chk("R1 ptr_new",  ptr_new,           16'h0000);
    endtask

    task automatic t_direct();
        issue(3'b000, 2'b01, 16'hFFFE, 16'h1234, 6'd5);
        expect_ok("R3 direct", 16'hFFFE, 16'h1234, 1'b0);
        issue(3'b000, 2'b11, 16'h0060, 16'h0000, 6'd0);
        expect_ok("R3 direct rsv sel", 16'h0060, 16'h0000, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        chk("R2 idle ea_valid", {15'd0, ea_valid}, 16'd0);
        chk("R2 idle illegal",  {15'd0, illegal},  16'd0);
        chk("R2 idle ptr_we",   {15'd0, ptr_we},   16'd0);
    endtask

    task automatic t_indirect();
        for (int s = 0; s < 3; s++) begin
            issue(3'b001, s[1:0], 16'hAAAA, 16'h0100 + 16'(s), 6'd9);
            expect_ok("R4 indirect", 16'h0100 + 16'(s), 16'h0100 + 16'(s), 1'b0);
        end
    endtask

    task automatic t_disp();
        issue(3'b010, 2'b01, 16'h0, 16'h0200, 6'd0);
        expect_ok("R5 disp Y 0", 16'h0200, 16'h0200, 1'b0);
        issue(3'b010, 2'b10, 16'h0, 16'h0200, 6'd63);
        expect_ok("R5 disp Z 63", 16'h023F, 16'h0200, 1'b0);
    endtask

    task automatic t_disp_x();
        issue(3'b010, 2'b00, 16'h0, 16'h0300, 6'd4);
        expect_bad("R6 disp X");
    endtask

    task automatic t_predec();
        issue(3'b011, 2'b10, 16'h0, 16'h0400, 6'd7);
        expect_ok("R7 predec", 16'h03FF, 16'h03FF, 1'b1);
        chk("R10 predec sel", {14'd0, ptr_wr_sel}, 16'd2);
    endtask

    task automatic t_postinc();
        issue(3'b100, 2'b00, 16'h0, 16'h0500, 6'd7);
        expect_ok("R8 postinc", 16'h0500, 16'h0501, 1'b1);
        chk("R10 postinc sel", {14'd0, ptr_wr_sel}, 16'd0);
        issue(3'b100, 2'b01, 16'h0, 16'h0777, 6'd0);
        chk("R10 postinc Y sel", {14'd0, ptr_wr_sel}, 16'd1);
    endtask

    task automatic t_wrap();
        issue(3'b011, 2'b01, 16'h0, 16'h0000, 6'd0);
        expect_ok("R9 predec wrap", 16'hFFFF, 16'hFFFF, 1'b1);
        issue(3'b100, 2'b10, 16'h0, 16'hFFFF, 6'd0);
        expect_ok("R9 postinc wrap", 16'hFFFF, 16'h0000, 1'b1);
        issue(3'b010, 2'b10, 16'h0, 16'hFFF0, 6'd63);
        expect_ok("R9 disp wrap", 16'h002F, 16'hFFF0, 1'b0);
    endtask

    task automatic t_bad_codes();
        for (int m = 5; m < 8; m++) begin
            issue(3'(m), 2'b01, 16'h0, 16'h0600, 6'd1);
            expect_bad("R11 mode code");
        end
        for (int m = 1; m < 5; m++) begin
            issue(3'(m), 2'b11, 16'h0, 16'h0600, 6'd1);
            expect_bad("R11 reserved sel");
        end
        issue(3'b011, 2'b10, 16'h0, 16'h0800, 6'd0);
        expect_ok("R2 recover after fault", 16'h07FF, 16'h07FF, 1'b1);
    endtask

    initial begin
        t_reset();
        t_direct();
        t_idle();
        t_indirect();
        t_disp();
        t_disp_x();
        t_predec();
        t_postinc();
        t_wrap();
        t_bad_codes();
        t_idle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule